// File: doc/BRIEF.md
# Indirect Address Space Decoder

This block sits between a 16-bit indirect pointer and three backing stores: banked general-purpose data RAM, a 256-byte data EEPROM and a 32K-word program flash with 14-bit words. For every read or write strobe it classifies the pointer into one of these windows, computes the physical address on the matching memory port, and steers the returned byte back to `rd_data`. Pointers that land in none of the windows are treated as empty space.

The RAM window is linear. Each bank is 128 bytes, of which only the 80 general-purpose bytes at bank offsets 0x20..0x6F are usable. The window packs those 80-byte slices back to back, so a buffer can run across a bank boundary with no gap. The two non-volatile windows are read-only. Their memories answer one cycle after the request, so the decoder holds `ready` low for one cycle on those reads.

The RAM port reads combinationally. The EEPROM and flash ports return data on the clock edge after their read enable.

Top module: `ptr_space_decode`

## Requirements
- R1: A pointer P in 0x2000..0x29AF addresses RAM. With o = P - 0x2000, `ram_addr` = (o / 80) * 128 + 0x20 + (o mod 80). A read asserts `ram_rd_en`, keeps `ready` high and returns `ram_rdata` on `rd_data` in the same cycle.
- R2: Consecutive pointers that cross an 80-byte boundary of the linear window move to offset 0x20 of the next bank. For example, 0x204F maps to 0x06F and 0x2050 maps to 0x0A0. The last pointer, 0x29AF, maps to 0xF6F.
- R3: Any RAM access through the window has a bank offset (`ram_addr` mod 128) in 0x20..0x6F and a bank number (`ram_addr` / 128) below 31. The common bytes at offsets 0x70..0x7F and the bytes at offsets 0x00..0x1F are never reached.
- R4: A write strobe in the linear window raises `ram_wr_en` for one cycle, with the R1 address and `ram_wdata` = `wr_data`, and `ready` stays high. A later read of the same pointer returns the written byte. The read and write strobes are never high together.
- R5: A read with pointer bits [15:8] = 0x70 drives `ee_addr` = pointer[7:0] and raises `ee_rd_en` in the first cycle, with `ready` low. In the next cycle `ready` is high and `rd_data` equals `ee_rdata`. The pointer and strobe stay stable across both cycles.
- R6: A read with pointer bit 15 set drives `pf_addr` = pointer[14:0] and raises `pf_rd_en` in the first cycle, with `ready` low. In the next cycle `ready` is high and `rd_data` = `pf_rdata`[7:0].
- R7: A write strobe to the EEPROM window, the flash window or empty space raises no memory enable and keeps `ready` high, and RAM contents are unchanged afterwards.
- R8: A read of a pointer in 0x0000..0x1FFF, 0x29B0..0x6FFF or 0x7100..0x7FFF returns 0x00 with `ready` high and no memory enable.
- R9: With no strobe, after reset and between accesses, `ready` is high, `rd_data` is 0x00 and no memory enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr | input | 16 | Indirect pointer |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid while `ready` is high |
| ready | output | 1 | Low during the stall cycle of a non-volatile read |
| ram_addr | output | 12 | Physical RAM address |
| ram_rd_en | output | 1 | RAM read enable |
| ram_wr_en | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte (combinational) |
| ee_addr | output | 8 | EEPROM byte address |
| ee_rd_en | output | 1 | EEPROM read enable |
| ee_rdata | input | 8 | EEPROM byte, one cycle after enable |
| pf_addr | output | 15 | Flash word address |
| pf_rd_en | output | 1 | Flash read enable |
| pf_rdata | input | 14 | Flash word, one cycle after enable |

## Verification
The assertions check the cycle-level rules on every clock:
- each RAM access stays inside a bank's general-purpose slice;
- only in-window writes reach the RAM;
- at most one memory enable is high at a time;
- a non-volatile request stalls for exactly one cycle and then releases;
- empty-space reads return zero;
- the idle outputs are quiet.

Only the bench scenarios can show that the divide-by-80 arithmetic lands on the correct bank and byte across the whole window, including the bank seams and the last byte. The same holds for correct data steering from each store, low flash bits only, and write-then-read agreement with an independent model.

// File: rtl/ptr_space_pkg.sv
package ptr_space_pkg;

    // Window that a pointer falls into
    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_RAM  = 2'd1,
        SPC_EE   = 2'd2,
        SPC_PF   = 2'd3
    } space_e;

    // State of the non-volatile wait sequencer
    typedef struct packed {
        logic   busy;
        space_e src;
    } wait_state_t;

endpackage

// File: rtl/ptr_region_classify.sv
module ptr_region_classify
    import ptr_space_pkg::*;
#(
    parameter int PTR_W    = 16,
    parameter int LIN_BASE = 'h2000,
    parameter int LIN_SIZE = 2480,
    parameter int EE_AW    = 8,
    parameter int EE_PAGE  = 'h70,
    parameter int OFF_W    = 12
) (
    input  logic [PTR_W-1:0] ptr,
    output space_e           space,
    output logic [OFF_W-1:0] lin_off
);
    localparam int LIN_LAST = LIN_BASE + LIN_SIZE - 1;
    localparam int PAGE_W   = PTR_W - EE_AW;

    always_comb begin
        // Flash takes the whole upper half, so it is tested first
        if (ptr[PTR_W-1]) begin
            space = SPC_PF;
        end else if (ptr[PTR_W-1 -: PAGE_W] == PAGE_W'(EE_PAGE)) begin
            space = SPC_EE;
        end else if (ptr >= PTR_W'(LIN_BASE) && ptr <= PTR_W'(LIN_LAST)) begin
            space = SPC_RAM;
        end else begin
            space = SPC_NONE;
        end
        lin_off = OFF_W'(ptr - PTR_W'(LIN_BASE));
    end

endmodule

// File: rtl/lin_bank_xlate.sv
module lin_bank_xlate #(
    parameter int OFF_W       = 12,
    parameter int ADDR_W      = 12,
    parameter int GPR_BYTES   = 80,
    parameter int BANK_BYTES  = 128,
    parameter int GPR_BASE    = 'h20,
    parameter int RECIP_SHIFT = 20
) (
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] phys
);
    // Reciprocal rounded up: exact quotient while off * error < 2**RECIP_SHIFT
    localparam int PROD_W  = OFF_W + RECIP_SHIFT;
    localparam int RECIP   = ((1 << RECIP_SHIFT) + GPR_BYTES - 1) / GPR_BYTES;
    localparam int BANK_SH = $clog2(BANK_BYTES);

    logic [OFF_W-1:0] bank_idx;
    logic [OFF_W-1:0] slot;

    always_comb begin
        bank_idx = OFF_W'((PROD_W'(off) * PROD_W'(RECIP)) >> RECIP_SHIFT);
        slot     = off - OFF_W'(bank_idx * OFF_W'(GPR_BYTES));
        phys     = (ADDR_W'(bank_idx) << BANK_SH) + ADDR_W'(GPR_BASE) + ADDR_W'(slot);
    end

endmodule

// File: rtl/nvm_wait_ctrl.sv
module nvm_wait_ctrl
    import ptr_space_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_en,
    input  space_e space,
    output logic   ready,
    output logic   issue,
    output logic   busy,
    output space_e src
);
    wait_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        issue = 1'b0;
        ready = 1'b1;
        if (st_q.busy) begin
            // Data cycle: the store has answered
            st_d.busy = 1'b0;
            st_d.src  = SPC_NONE;
        end else if (rd_en && (space == SPC_EE || space == SPC_PF)) begin
            st_d.busy = 1'b1;
            st_d.src  = space;
            issue     = 1'b1;
            ready     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, src: SPC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign src  = st_q.src;

    // R5
    stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (rd_en && $stable(space)));

endmodule

// File: rtl/ptr_space_decode.sv
module ptr_space_decode
    import ptr_space_pkg::*;
#(
    parameter int PTR_W       = 16,
    parameter int DATA_W      = 8,
    parameter int RAM_AW      = 12,
    parameter int EE_AW       = 8,
    parameter int PF_W        = 14,
    parameter int LIN_BASE    = 'h2000,
    parameter int GPR_BYTES   = 80,
    parameter int BANK_BYTES  = 128,
    parameter int GPR_BASE    = 'h20,
    parameter int NUM_BANKS   = 31,
    parameter int EE_PAGE     = 'h70,
    parameter int RECIP_SHIFT = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_rd_en,
    output logic              ram_wr_en,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [EE_AW-1:0]  ee_addr,
    output logic              ee_rd_en,
    input  logic [DATA_W-1:0] ee_rdata,
    output logic [PTR_W-2:0]  pf_addr,
    output logic              pf_rd_en,
    input  logic [PF_W-1:0]   pf_rdata
);
    localparam int LIN_SIZE = NUM_BANKS * GPR_BYTES;
    localparam int LIN_LAST = LIN_BASE + LIN_SIZE - 1;
    localparam int OFF_W    = $clog2(LIN_SIZE);
    localparam int BANK_SH  = $clog2(BANK_BYTES);

    space_e              space;
    space_e              nvm_src;
    logic [OFF_W-1:0]    lin_off;
    logic [RAM_AW-1:0]   phys;
    logic                nvm_issue;
    logic                nvm_busy;
    logic [DATA_W-1:0]   pf_byte;

    ptr_region_classify #(
        .PTR_W(PTR_W), .LIN_BASE(LIN_BASE), .LIN_SIZE(LIN_SIZE),
        .EE_AW(EE_AW), .EE_PAGE(EE_PAGE), .OFF_W(OFF_W)
    ) u_classify (
        .ptr(ptr), .space(space), .lin_off(lin_off)
    );

    lin_bank_xlate #(
        .OFF_W(OFF_W), .ADDR_W(RAM_AW), .GPR_BYTES(GPR_BYTES),
        .BANK_BYTES(BANK_BYTES), .GPR_BASE(GPR_BASE), .RECIP_SHIFT(RECIP_SHIFT)
    ) u_xlate (
        .off(lin_off), .phys(phys)
    );

    nvm_wait_ctrl u_wait (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .space(space),
        .ready(ready), .issue(nvm_issue), .busy(nvm_busy), .src(nvm_src)
    );

    assign ram_addr  = phys;
    assign ram_rd_en = rd_en && (space == SPC_RAM);
    assign ram_wr_en = wr_en && (space == SPC_RAM);
    assign ram_wdata = wr_data;
    assign ee_addr   = ptr[EE_AW-1:0];
    assign pf_addr   = ptr[PTR_W-2:0];
    assign ee_rd_en  = nvm_issue && (space == SPC_EE);
    assign pf_rd_en  = nvm_issue && (space == SPC_PF);
    assign pf_byte   = DATA_W'(pf_rdata);

    always_comb begin
        rd_data = '0;
        if (nvm_busy) begin
            case (nvm_src)
                SPC_EE:  rd_data = ee_rdata;
                SPC_PF:  rd_data = pf_byte;
                default: rd_data = '0;
            endcase
        end else if (ram_rd_en) begin
            rd_data = ram_rdata;
        end
    end

    // R7
    write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_en |-> (wr_en && ptr >= PTR_W'(LIN_BASE) && ptr <= PTR_W'(LIN_LAST)));

    // R3
    gpr_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en || ram_wr_en) |->
            ((ram_addr & RAM_AW'(BANK_BYTES - 1)) >= RAM_AW'(GPR_BASE)
             && (ram_addr & RAM_AW'(BANK_BYTES - 1)) < RAM_AW'(GPR_BASE + GPR_BYTES)
             && (ram_addr >> BANK_SH) < RAM_AW'(NUM_BANKS)));

    // R1
    enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_rd_en, ram_wr_en, ee_rd_en, pf_rd_en}));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R8
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && space == SPC_NONE) |->
            (ready && rd_data == '0 && !ram_rd_en && !ee_rd_en && !pf_rd_en));

    // R5
    nvm_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_rd_en || pf_rd_en) |-> !ready);

    // R6
    nvm_single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_rd_en || pf_rd_en) |=> (ready && !ee_rd_en && !pf_rd_en));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en && !nvm_busy) |->
            (ready && rd_data == '0 && !ram_rd_en && !ram_wr_en && !ee_rd_en && !pf_rd_en));

endmodule

// File: tb/sim_ptr_space_decode.sv
module sim_ptr_space_decode;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] ptr;
    logic        rd_en, wr_en;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic        ready;
    logic [11:0] ram_addr;
    logic        ram_rd_en, ram_wr_en;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [7:0]  ee_addr;
    logic        ee_rd_en;
    logic [7:0]  ee_rdata;
    logic [14:0] pf_addr;
    logic        pf_rd_en;
    logic [13:0] pf_rdata;

    always #2 clk = ~clk;   // 250 MHz

    ptr_space_decode u0 (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ready(ready),
        .ram_addr(ram_addr), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .ee_addr(ee_addr), .ee_rd_en(ee_rd_en), .ee_rdata(ee_rdata),
        .pf_addr(pf_addr), .pf_rd_en(pf_rd_en), .pf_rdata(pf_rdata)
    );

    function automatic logic [7:0] ram_init(input int a);
        return 8'(a ^ (a >> 4) ^ 'h5C);
    endfunction

    function automatic logic [7:0] ee_fn(input logic [7:0] a);
        return 8'(a * 7) ^ 8'hA5;
    endfunction

    function automatic logic [13:0] pf_fn(input logic [14:0] w);
        return {w[13:8] ^ 6'h2B, w[7:0] ^ {w[14:8], 1'b1} ^ 8'h96};
    endfunction

    // Behavioural stores
    logic [7:0] ram_mem [0:4095];
    logic [7:0] exp_ram [0:4095];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) ram_mem[i] <= ram_init(i);
        end else if (ram_wr_en) begin
            ram_mem[ram_addr] <= ram_wdata;
        end
    end
    assign ram_rdata = ram_mem[ram_addr];

    always @(posedge clk) begin
        if (ee_rd_en) ee_rdata <= ee_fn(ee_addr);
        if (pf_rd_en) pf_rdata <= pf_fn(pf_addr);
    end

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input int req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // kind: 0 RAM, 1 EEPROM, 2 flash, 3 empty
    function automatic int kind_of(input logic [15:0] p);
        if (p[15]) return 2;
        if (p[15:8] == 8'h70) return 1;
        if (p >= 16'h2000 && p <= 16'h29AF) return 0;
        return 3;
    endfunction

    function automatic logic [11:0] lin_phys(input logic [15:0] p);
        int o;
        o = int'(p) - 'h2000;
        return 12'((o / 80) * 128 + 'h20 + (o % 80));
    endfunction

    typedef struct {
        int          req;
        bit          is_wr;
        int          kind;
        logic [14:0] addr;
        logic [7:0]  data;
    } item_t;

    item_t q[$];

    task automatic do_rd(input logic [15:0] p, input int req);
        item_t       it;
        logic [13:0] w;
        it.req   = req;
        it.is_wr = 1'b0;
        it.kind  = kind_of(p);
        it.addr  = '0;
        it.data  = '0;
        case (it.kind)
            0: begin it.addr = 15'(lin_phys(p)); it.data = exp_ram[lin_phys(p)]; end
            1: begin it.addr = 15'(p[7:0]); it.data = ee_fn(p[7:0]); end
            2: begin it.addr = p[14:0]; w = pf_fn(p[14:0]); it.data = w[7:0]; end
            default: ;
        endcase
        q.push_back(it);
        ptr   = p;
        rd_en = 1'b1;
        repeat ((it.kind == 1 || it.kind == 2) ? 2 : 1) begin
            @(posedge clk); #1;
        end
        rd_en = 1'b0;
    endtask

    task automatic do_wr(input logic [15:0] p, input logic [7:0] d, input int req);
        item_t it;
        it.req   = req;
        it.is_wr = 1'b1;
        it.kind  = kind_of(p);
        it.addr  = (it.kind == 0) ? 15'(lin_phys(p)) : '0;
        it.data  = d;
        if (it.kind == 0) exp_ram[lin_phys(p)] = d;
        q.push_back(it);
        ptr     = p;
        wr_data = d;
        wr_en   = 1'b1;
        @(posedge clk); #1;
        wr_en   = 1'b0;
    endtask

    // Monitor: compare outputs with the head of the scoreboard
    int    waits = 0;
    item_t cur;
    always @(negedge clk) begin
        if (rst_n && (rd_en || wr_en)) begin
            if (q.size() == 0) begin
                chk(1'b0, 9, "strobe with empty scoreboard", 1, 0);
            end else begin
                cur = q[0];
                if (cur.is_wr) begin
                    if (cur.kind == 0)
                        chk(ram_wr_en && ready && !ram_rd_en && !ee_rd_en && !pf_rd_en
                            && ram_addr == cur.addr[11:0] && ram_wdata == cur.data,
                            cur.req, "ram write addr/data",
                            int'({ram_wr_en, ram_addr, ram_wdata}),
                            int'({1'b1, cur.addr[11:0], cur.data}));
                    else
                        chk(ready && !ram_wr_en && !ram_rd_en && !ee_rd_en && !pf_rd_en,
                            cur.req, "dropped write ready/enables",
                            int'({ready, ram_wr_en, ram_rd_en, ee_rd_en, pf_rd_en}),
                            int'(5'b10000));
                    void'(q.pop_front());
                end else if (cur.kind == 1 || cur.kind == 2) begin
                    if (!ready) begin
                        waits++;
                        if (waits == 1) begin
                            if (cur.kind == 1)
                                chk(ee_rd_en && !pf_rd_en && !ram_rd_en && ee_addr == cur.addr[7:0],
                                    cur.req, "eeprom request", int'({ee_rd_en, ee_addr}),
                                    int'({1'b1, cur.addr[7:0]}));
                            else
                                chk(pf_rd_en && !ee_rd_en && !ram_rd_en && pf_addr == cur.addr,
                                    cur.req, "flash request", int'({pf_rd_en, pf_addr}),
                                    int'({1'b1, cur.addr}));
                        end
                    end else begin
                        chk(waits == 1 && rd_data == cur.data, cur.req, "stall count/data",
                            (waits << 8) | int'(rd_data), (1 << 8) | int'(cur.data));
                        waits = 0;
                        void'(q.pop_front());
                    end
                end else if (cur.kind == 0) begin
                    chk(ready && ram_rd_en && !ee_rd_en && !pf_rd_en
                        && ram_addr == cur.addr[11:0] && rd_data == cur.data,
                        cur.req, "ram read addr/data",
                        int'({ready, ram_addr, rd_data}),
                        int'({1'b1, cur.addr[11:0], cur.data}));
                    void'(q.pop_front());
                end else begin
                    chk(ready && rd_data == 8'h00 && !ram_rd_en && !ee_rd_en && !pf_rd_en,
                        cur.req, "empty read", int'({ready, rd_data}), int'({1'b1, 8'h00}));
                    void'(q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n   = 1'b0;
        ptr     = '0;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        for (int i = 0; i < 4096; i++) exp_ram[i] = ram_init(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(ready && rd_data == 8'h00 && !ram_rd_en && !ram_wr_en && !ee_rd_en && !pf_rd_en,
            9, "reset outputs", int'({ready, rd_data}), int'({1'b1, 8'h00}));
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 window ends and a sweep
        do_rd(16'h2000, 1);
        do_rd(16'h29AF, 1);
        for (int o = 0; o < 2480; o += 53) do_rd(16'(16'h2000 + o), 1);
        // R2 bank seams
        do_rd(16'h204F, 2);
        do_rd(16'h2050, 2);
        do_rd(16'h209F, 2);
        do_rd(16'h20A0, 2);
        do_rd(16'h295F, 2);
        do_rd(16'h2960, 2);
        // R3 whole-window walk, address slice checked per access
        for (int o = 7; o < 2480; o += 97) do_rd(16'(16'h2000 + o), 3);
        // R4 writes then read back
        do_wr(16'h2051, 8'hC3, 4);
        do_wr(16'h29AF, 8'h3E, 4);
        do_wr(16'h2000, 8'h81, 4);
        do_rd(16'h2051, 4);
        do_rd(16'h29AF, 4);
        do_rd(16'h2000, 4);
        // R5 EEPROM reads, including back-to-back with RAM
        do_rd(16'h7000, 5);
        do_rd(16'h70FF, 5);
        do_rd(16'h7042, 5);
        do_rd(16'h2010, 5);
        do_rd(16'h7043, 5);
        // R6 flash reads
        do_rd(16'h8000, 6);
        do_rd(16'hFFFF, 6);
        do_rd(16'h9234, 6);
        do_rd(16'h7044, 6);
        do_rd(16'hC0DE, 6);
        // R7 dropped writes, then RAM unchanged
        do_wr(16'h7010, 8'h11, 7);
        do_wr(16'h8005, 8'h22, 7);
        do_wr(16'h1000, 8'h33, 7);
        do_wr(16'h29B0, 8'h44, 7);
        do_rd(16'h2000, 7);
        do_rd(16'h2051, 7);
        do_rd(16'h7010, 7);
        // R8 empty-space reads
        do_rd(16'h0000, 8);
        do_rd(16'h1FFF, 8);
        do_rd(16'h29B0, 8);
        do_rd(16'h6FFF, 8);
        do_rd(16'h7100, 8);
        do_rd(16'h7FFF, 8);

        @(negedge clk);
        // R9 idle between accesses
        chk(ready && rd_data == 8'h00 && !ram_rd_en && !ram_wr_en && !ee_rd_en && !pf_rd_en,
            9, "idle outputs", int'({ready, rd_data}), int'({1'b1, 8'h00}));
        chk(q.size() == 0, 9, "scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule